// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a six-entry, byte-wide instruction queue placed between a bus fetch engine and an execution consumer. The fetch side runs ahead of execution. It raises a request whenever at least two slots are free. The fetch engine answers with one or two code bytes and a fetch address that the queue maintains itself. Bytes settle toward the output end, so the oldest byte is always presented to the consumer.

The consumer takes one byte per cycle from the output end. It tags each pop as either the opening byte of an instruction or a later byte of one. When control flow changes, a flush input empties the queue in a single cycle and reloads the fetch address with the new target. A two-bit status code reports what the queue does in each cycle, so that outside logic can follow its contents.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset the queue is empty: `q_empty`=1 and `q_count`=0. `fetch_addr` equals `RESET_ADDR`, `q_status`=00 and `fetch_req`=1.
- R2: Bytes leave in the order they arrived, with the oldest on `q_byte`. In a two-byte fetch, `fetch_data[7:0]` is queued before `fetch_data[15:8]`.
- R3: The queue never holds more than six bytes.
- R4: `fetch_req` is 1 only while at least two slots are free and `flush` is 0. A `fetch_ack` that arrives while `fetch_req` is 0 writes nothing.
- R5: On each accepted fetch, `fetch_addr` advances by the number of bytes written: 2 when `fetch_two`=1, otherwise 1.
- R6: A `flush` leaves the queue empty after one clock edge. It discards any fetch data and any pop in the same cycle, and it loads `fetch_addr` from `flush_addr`.
- R7: `q_status` reports the operation of the current cycle: 00 idle, 01 a pop marked first byte (`pop_first`=1), 10 flush, 11 a pop of a later byte. A flush takes precedence over a pop.
- R8: A pop and an accepted fetch in the same cycle both take effect.
- R9: A pop while the queue is empty is ignored: the count stays 0, `q_empty` stays 1 and `q_status` stays 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue and reload the fetch address |
| flush_addr | input | AW | New fetch target loaded on flush |
| fetch_req | output | 1 | Queue has room for a two-byte fetch |
| fetch_addr | output | AW | Address of the next code byte to fetch |
| fetch_ack | input | 1 | Fetch data valid this cycle |
| fetch_two | input | 1 | Fetch carries two bytes (else low byte only) |
| fetch_data | input | 16 | Fetched code bytes, low byte first in address order |
| pop | input | 1 | Consumer takes the output byte |
| pop_first | input | 1 | Popped byte opens a new instruction |
| q_byte | output | 8 | Oldest queued byte |
| q_empty | output | 1 | Queue holds no bytes |
| q_count | output | 3 | Number of bytes held |
| q_status | output | 2 | Per-cycle queue operation code |

## Verification
A wrong occupancy count shows up one edge after the faulty update. `q_count` and `q_empty` go wrong at once, and `fetch_req` then rises or falls at the wrong fill level. A wrong write position or shift corrupts the order of bytes on `q_byte`. That is seen on the next pop, so the bench drains every filled pattern and compares each byte. A fault in flush or address handling shows in `fetch_addr` within one cycle, before any further fetch is granted.

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int AW = 20,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic          fetch_two,
  input  logic [15:0]   fetch_data,
  input  logic          pop,
  input  logic          pop_first,
  output logic [7:0]    q_byte,
  output logic          q_empty,
  output logic [CW-1:0] q_count,
  output logic [1:0]    q_status
);

  logic [7:0]    slot [DEPTH];
  logic [7:0]    shifted [DEPTH];
  logic [CW-1:0] count;
  logic [AW-1:0] addr;

  wire          room  = count <= CW'(DEPTH - 2);
  assign        fetch_req = room & ~flush;
  wire          push  = fetch_ack & fetch_req;
  wire          take  = pop & (count != '0) & ~flush;
  wire [CW-1:0] nbytes = push ? (fetch_two ? CW'(2) : CW'(1)) : '0;
  wire [CW-1:0] wp    = count - CW'(take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      addr  <= RESET_ADDR;
    end else if (flush) begin
      count <= '0;
      addr  <= flush_addr;
    end else begin
      count <= wp + nbytes;
      addr  <= addr + AW'(nbytes);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      assign shifted[i] = slot[i+1];
    end else begin : g_top
      assign shifted[i] = 8'h00;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[i] <= 8'h00;
      else if (!flush) begin
        if (push && CW'(i) == wp)
          slot[i] <= fetch_data[7:0];
        else if (push && fetch_two && CW'(i) == wp + CW'(1))
          slot[i] <= fetch_data[15:8];
        else if (take)
          slot[i] <= shifted[i];
      end
    end
  end

  assign q_byte     = slot[0];
  assign q_empty    = (count == '0);
  assign q_count    = count;
  assign fetch_addr = addr;
  assign q_status   = flush ? 2'b10 : take ? (pop_first ? 2'b01 : 2'b11) : 2'b00;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH)); // R3
  AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (q_count <= CW'(DEPTH - 2)) && !flush); // R4
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> q_empty && (fetch_addr == $past(flush_addr))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack) |=> fetch_addr == $past(fetch_addr) + ($past(fetch_two) ? AW'(2) : AW'(1))); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && pop && !fetch_ack) |-> q_status != 2'b01 && q_status != 2'b11); // R9
  AST_POP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fetch_req && fetch_ack && fetch_two && !q_empty) |=> q_count == $past(q_count) + CW'(1)); // R8

endmodule

// File: tb/code_prefetch_queue_tb.sv
module code_prefetch_queue_tb;
  logic clk = 0, rst_n = 0;
  logic flush = 0, fetch_ack = 0, fetch_two = 0, pop = 0, pop_first = 0;
  logic [19:0] flush_addr = '0;
  logic [15:0] fetch_data = '0;
  logic fetch_req, q_empty;
  logic [19:0] fetch_addr;
  logic [7:0] q_byte;
  logic [2:0] q_count;
  logic [1:0] q_status;

  int tests = 0, fails = 0;
  int mq [8];
  int mcnt = 0;
  int maddr = 32'hFFFF0;

  always #2.5 clk = ~clk;

  code_prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_two(fetch_two), .fetch_data(fetch_data), .pop(pop), .pop_first(pop_first),
    .q_byte(q_byte), .q_empty(q_empty), .q_count(q_count), .q_status(q_status));

  task automatic chk(input int act, input int exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(int'(q_count), mcnt, {tag, " count"});
    chk(int'(q_empty), int'(mcnt == 0), {tag, " empty"});
    chk(int'(fetch_addr), maddr, {tag, " addr"});
    if (mcnt > 0) chk(int'(q_byte), mq[0], {tag, " head byte"});
  endtask

  task automatic step(input bit fl, input int fa, input bit ack, input bit two,
                      input int data, input bit p, input bit pf, input string tag);
    bit req, pushok, popok;
    @(negedge clk);
    flush = fl; flush_addr = fa[19:0]; fetch_ack = ack; fetch_two = two;
    fetch_data = data[15:0]; pop = p; pop_first = pf;
    #1;
    req = !fl && (6 - mcnt) >= 2;
    pushok = ack && req;
    popok = p && mcnt > 0 && !fl;
    chk(int'(fetch_req), int'(req), {tag, " R4 fetch_req"});
    chk(int'(q_status), fl ? 2 : popok ? (pf ? 1 : 3) : 0, {tag, " R7 status"});
    @(posedge clk);
    if (fl) begin
      mcnt = 0; maddr = fa;
    end else begin
      if (popok) begin
        for (int i = 0; i < 7; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (pushok) begin
        mq[mcnt] = data & 8'hFF; mcnt++;
        if (two) begin mq[mcnt] = (data >> 8) & 8'hFF; mcnt++; end
        maddr = (maddr + (two ? 2 : 1)) & 20'hFFFFF;
      end
    end
    @(negedge clk);
    flush = 0; fetch_ack = 0; pop = 0; pop_first = 0; fetch_two = 0;
    check_state(tag);
  endtask

  task automatic t_reset;
    #1;
    chk(int'(q_empty), 1, "R1 empty at reset");
    chk(int'(q_count), 0, "R1 count at reset");
    chk(int'(fetch_addr), 32'hFFFF0, "R1 addr at reset");
    chk(int'(q_status), 0, "R1 status at reset");
    chk(int'(fetch_req), 1, "R1 req at reset");
  endtask

  task automatic t_fill_and_drain;
    step(0, 0, 1, 1, 16'hB2A1, 0, 0, "R2 R5 word0");
    step(0, 0, 1, 1, 16'hD4C3, 0, 0, "R2 word1");
    step(0, 0, 1, 1, 16'hF6E5, 0, 0, "R3 word2 full");
    chk(int'(q_count), 6, "R3 six held");
    step(0, 0, 1, 1, 16'h9988, 0, 0, "R4 ack ignored when full");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1, k == 0, "R2 drain");
    step(0, 0, 0, 0, 0, 1, 1, "R9 pop empty");
    step(0, 0, 0, 0, 0, 1, 0, "R9 pop empty later");
  endtask

  task automatic t_mixed;
    step(0, 0, 1, 0, 16'h0011, 0, 0, "R5 single byte");
    step(0, 0, 1, 1, 16'h3322, 1, 1, "R8 pop with push");
    step(0, 0, 1, 1, 16'h5544, 1, 0, "R8 pop with push 2");
    step(0, 0, 1, 0, 16'h0066, 1, 0, "R8 pop with single push");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 1, k[0], "R2 drain mixed");
  endtask

  task automatic t_flush;
    step(0, 0, 1, 1, 16'h2211, 0, 0, "R6 prefill");
    step(0, 0, 1, 1, 16'h4433, 0, 0, "R6 prefill 2");
    step(1, 20'h12345, 1, 1, 16'h7777, 1, 1, "R6 flush with ack and pop");
    chk(int'(q_empty), 1, "R6 empty after flush");
    step(0, 0, 1, 1, 16'hBBAA, 0, 0, "R6 refetch after flush");
    step(0, 0, 0, 0, 0, 1, 1, "R6 first byte after flush");
    step(0, 0, 0, 0, 0, 1, 0, "R6 second byte after flush");
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_and_drain();
    t_mixed();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule